// File: doc/BRIEF.md
# Single-Precision Floating-Point Comparator

This block takes two 32-bit IEEE-754 single-precision operands and a 3-bit predicate code, and returns the truth of that predicate as a 32-bit word. The word is 1 for true and 0 for false. Along with the result it gives a destination write enable and two exception flags: illegal operation and denormalized operand. When either flag is raised, the write enable is low, so the register that would have taken the result keeps its old value. The flags and the write enable are all the block produces. Any trap or vectoring is left to the surrounding pipeline.

Operands enter through a valid/ready stream and results leave through a second valid/ready stream. A single output register separates the two. An input is accepted on any clock edge where `in_valid` and `in_ready` are both high. The result appears on the output one cycle later. The input stays ready while the output register is empty or is being drained in that same cycle, so full throughput is kept under continuous `out_ready`. When `out_ready` is low, the output holds and back-pressure reaches the input in the same cycle.

Top module: `fp_compare_unit`

## Requirements
- R1: Predicate code 0 is less-than, 1 is equal, 2 is less-or-equal, 3 is greater-than, 4 is not-equal, 5 is greater-or-equal and 6 is unordered. The result is 32'h1 when the predicate holds and 32'h0 when it does not.
- R2: An operand is a NaN when its exponent field (bits 30:23) is all ones and its fraction field (bits 22:0) is nonzero. The unordered predicate is true exactly when at least one operand is a NaN.
- R3: +0 (32'h00000000) and -0 (32'h80000000) are equal under every predicate.
- R4: A signaling NaN has fraction bit 22 clear. If either operand is a signaling NaN, the illegal-operation flag is raised for every predicate.
- R5: A quiet NaN has fraction bit 22 set. With a quiet NaN and no signaling NaN:
  - the four ordered relations (codes 0, 2, 3, 5) raise illegal operation;
  - equal returns 0 and not-equal returns 1, without a flag;
  - unordered returns 1, without a flag.
- R6: An operand is subnormal when its exponent field is zero and its fraction is nonzero. A subnormal operand raises the denormalized-operand flag, unless illegal operation is raised for the same compare. Illegal operation has priority, so the two flags are never high together.
- R7: Whenever an exception flag is high, the write enable is 0 and the result is 32'h0. Otherwise the write enable is 1.
- R8: Predicate code 7 is undefined. It raises illegal operation.
- R9: `in_ready` equals `!out_valid || out_ready`. An accepted input produces `out_valid` with its result at the next clock edge. While `out_valid` is high and `out_ready` is low, every output holds its value.
- R10: While reset is asserted and after it is released, `out_valid` is 0 until the first input is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and predicate are offered |
| in_ready | output | 1 | Block can take an input this cycle |
| in_a | input | 32 | First operand, single precision |
| in_b | input | 32 | Second operand, single precision |
| in_pred | input | 3 | Predicate code |
| out_valid | output | 1 | Result registers hold a compare |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 32 | 32'h1 true, 32'h0 false |
| out_wr_en | output | 1 | Destination write allowed |
| out_invalid | output | 1 | Illegal-operation exception |
| out_denorm | output | 1 | Denormalized-operand exception |

## Verification
The hardest situations to reach from the ports are collisions between operand classes. One case is a signaling NaN paired with a subnormal, where the priority between the two flags decides the outcome. Another is a quiet NaN under each predicate, and a third is a pair of zeros of opposite sign. Uniform random words almost never land on these, so the stimulus draws each operand from weighted classes: zeros of either sign, infinities, quiet and signaling NaNs, subnormals, a copy or a sign-flipped copy of the other operand, and plain random words. The predicate code, including the undefined one, is drawn at random. `out_ready` is toggled at random to hold results under back-pressure, and directed cases pin down the flag-priority collisions.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

  // Predicate select codes; the numbering is part of the block's interface.
  typedef enum logic [2:0] {
    PRED_LT  = 3'd0,
    PRED_EQ  = 3'd1,
    PRED_LE  = 3'd2,
    PRED_GT  = 3'd3,
    PRED_NE  = 3'd4,
    PRED_GE  = 3'd5,
    PRED_UN  = 3'd6,
    PRED_RSV = 3'd7
  } pred_e;

  // Operand classification produced once per operand.
  typedef struct packed {
    logic sign;
    logic is_zero;
    logic is_sub;
    logic is_inf;
    logic is_nan;
    logic is_snan;
  } op_class_t;

  // Outcome of one compare before it is registered.
  typedef struct packed {
    logic truth;
    logic wr_en;
    logic invalid;
    logic denorm;
  } cmp_out_t;

endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify
  import fpcmp_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] word,
  output op_class_t              cls
);
  localparam int WORD_W = EXP_W + FRAC_W + 1;

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              exp_ones;
  logic              exp_zero;
  logic              frac_nz;

  assign exp_f  = word[WORD_W-2 -: EXP_W];
  assign frac_f = word[FRAC_W-1:0];

  always_comb begin
    exp_ones    = &exp_f;
    exp_zero    = ~|exp_f;
    frac_nz     = |frac_f;
    cls.sign    = word[WORD_W-1];
    cls.is_zero = exp_zero && !frac_nz;
    cls.is_sub  = exp_zero && frac_nz;
    cls.is_inf  = exp_ones && !frac_nz;
    cls.is_nan  = exp_ones && frac_nz;
    // quiet bit is the top fraction bit; clear means signaling
    cls.is_snan = exp_ones && frac_nz && !frac_f[FRAC_W-1];
  end
endmodule

// File: rtl/fpcmp_relate.sv
module fpcmp_relate
  import fpcmp_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] a,
  input  logic [EXP_W+FRAC_W:0] b,
  input  op_class_t              cls_a,
  input  op_class_t              cls_b,
  output logic                   a_lt_b,
  output logic                   a_eq_b
);
  localparam int MAG_W = EXP_W + FRAC_W;

  logic [MAG_W-1:0] mag_a;
  logic [MAG_W-1:0] mag_b;
  logic             both_zero;
  logic             mag_lt;
  logic             mag_gt;

  assign mag_a = a[MAG_W-1:0];
  assign mag_b = b[MAG_W-1:0];

  // Ordered relation only; NaN handling is resolved downstream.
  always_comb begin
    both_zero = cls_a.is_zero && cls_b.is_zero;
    mag_lt    = mag_a < mag_b;
    mag_gt    = mag_a > mag_b;
    a_eq_b    = both_zero || (a == b);
    if (both_zero) begin
      a_lt_b = 1'b0;
    end else if (cls_a.sign != cls_b.sign) begin
      a_lt_b = cls_a.sign;
    end else if (cls_a.sign) begin
      a_lt_b = mag_gt;
    end else begin
      a_lt_b = mag_lt;
    end
  end
endmodule

// File: rtl/fpcmp_resolve.sv
module fpcmp_resolve
  import fpcmp_pkg::*;
(
  input  logic [2:0] pred,
  input  op_class_t  cls_a,
  input  op_class_t  cls_b,
  input  logic       a_lt_b,
  input  logic       a_eq_b,
  output cmp_out_t   res
);
  pred_e sel;
  logic  unord;
  logic  ord;
  logic  any_snan;
  logic  any_sub;
  logic  relational;
  logic  raw_truth;
  logic  inv;
  logic  den;

  assign sel = pred_e'(pred);

  always_comb begin
    unord      = cls_a.is_nan || cls_b.is_nan;
    ord        = !unord;
    any_snan   = cls_a.is_snan || cls_b.is_snan;
    any_sub    = cls_a.is_sub || cls_b.is_sub;
    relational = (sel == PRED_LT) || (sel == PRED_LE) ||
                 (sel == PRED_GT) || (sel == PRED_GE);
    unique case (sel)
      PRED_LT:  raw_truth = ord && a_lt_b;
      PRED_EQ:  raw_truth = ord && a_eq_b;
      PRED_LE:  raw_truth = ord && (a_lt_b || a_eq_b);
      PRED_GT:  raw_truth = ord && !a_lt_b && !a_eq_b;
      PRED_NE:  raw_truth = !(ord && a_eq_b);
      PRED_GE:  raw_truth = ord && !a_lt_b;
      PRED_UN:  raw_truth = unord;
      default:  raw_truth = 1'b0;
    endcase
    inv = any_snan || (unord && relational) || (sel == PRED_RSV);
    den = any_sub && !inv;
    res.invalid = inv;
    res.denorm  = den;
    res.wr_en   = !(inv || den);
    res.truth   = raw_truth && !(inv || den);
  end
endmodule

// File: rtl/fp_compare_unit.sv
module fp_compare_unit
  import fpcmp_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int RES_W  = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [EXP_W+FRAC_W:0]  in_a,
  input  logic [EXP_W+FRAC_W:0]  in_b,
  input  logic [2:0]             in_pred,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [RES_W-1:0]       out_result,
  output logic                   out_wr_en,
  output logic                   out_invalid,
  output logic                   out_denorm
);
  localparam int WORD_W = EXP_W + FRAC_W + 1;
  localparam int N_OPS  = 2;

  logic [WORD_W-1:0] ops [N_OPS];
  op_class_t         cls [N_OPS];
  logic              a_lt_b;
  logic              a_eq_b;
  cmp_out_t          nxt;
  logic              take;

  assign ops[0] = in_a;
  assign ops[1] = in_b;

  for (genvar gi = 0; gi < N_OPS; gi++) begin : g_cls
    fpcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .word (ops[gi]),
      .cls  (cls[gi])
    );
  end

  fpcmp_relate #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_rel (
    .a      (in_a),
    .b      (in_b),
    .cls_a  (cls[0]),
    .cls_b  (cls[1]),
    .a_lt_b (a_lt_b),
    .a_eq_b (a_eq_b)
  );

  fpcmp_resolve u_res (
    .pred   (in_pred),
    .cls_a  (cls[0]),
    .cls_b  (cls[1]),
    .a_lt_b (a_lt_b),
    .a_eq_b (a_eq_b),
    .res    (nxt)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_wr_en   <= 1'b0;
      out_invalid <= 1'b0;
      out_denorm  <= 1'b0;
    end else if (take) begin
      out_valid   <= 1'b1;
      out_result  <= {{(RES_W-1){1'b0}}, nxt.truth};
      out_wr_en   <= nxt.wr_en;
      out_invalid <= nxt.invalid;
      out_denorm  <= nxt.denorm;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end

  // Output stage holds while stalled.
  assert_hold_stalled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) &&
      $stable(out_wr_en) && $stable(out_invalid) && $stable(out_denorm)));

  // An accepted input shows up one edge later.
  assert_accept_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // Exceptions cancel the destination write and clear the result.
  assert_no_write_on_exc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_invalid || out_denorm)) |-> (!out_wr_en && out_result == '0));

  // Illegal operation has priority over the denormal flag.
  assert_flag_priority_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_invalid && out_denorm));

  // Result is a pure boolean word.
  assert_bool_result_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_result[RES_W-1:1] == '0));

  // Signaling NaN input always ends as illegal operation.
  assert_snan_invalid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (cls[0].is_snan || cls[1].is_snan)) |=> out_invalid);
endmodule

// File: tb/fp_compare_unit_test.sv
module fp_compare_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] in_a;
  logic [31:0] in_b;
  logic [2:0]  in_pred;
  logic        out_valid;
  logic        out_ready;
  logic [31:0] out_result;
  logic        out_wr_en;
  logic        out_invalid;
  logic        out_denorm;

  int checks = 0;
  int fails  = 0;
  logic [34:0] exp_q [$];
  int          tag_q [$];
  logic        held_pending = 1'b0;
  logic [34:0] held_val;

  always #2 clk = ~clk;

  fp_compare_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_pred(in_pred), .out_valid(out_valid),
    .out_ready(out_ready), .out_result(out_result), .out_wr_en(out_wr_en),
    .out_invalid(out_invalid), .out_denorm(out_denorm)
  );

  function automatic logic is_nan(input logic [31:0] x);
    return (x[30:23] == 8'hFF) && (x[22:0] != 0);
  endfunction
  function automatic logic is_sub(input logic [31:0] x);
    return (x[30:23] == 8'h00) && (x[22:0] != 0);
  endfunction
  // Monotone integer key for ordered values; both zeros share one key.
  function automatic logic [31:0] okey(input logic [31:0] x);
    if (x[30:0] == 0) return 32'h8000_0000;
    return x[31] ? ~x : (x | 32'h8000_0000);
  endfunction

  // Returns {result[31:0], wr_en, invalid, denorm}.
  function automatic logic [34:0] model(input logic [31:0] a, input logic [31:0] b,
                                        input logic [2:0] p);
    logic na, nb, sn, un, inv, den, t;
    logic [31:0] ka, kb;
    na = is_nan(a); nb = is_nan(b);
    sn = (na && !a[22]) || (nb && !b[22]);
    un = na || nb;
    ka = okey(a); kb = okey(b);
    inv = sn || (p == 3'd7) || (un && (p == 3'd0 || p == 3'd2 || p == 3'd3 || p == 3'd5));
    den = !inv && (is_sub(a) || is_sub(b));
    case (p)
      3'd0: t = !un && (ka < kb);
      3'd1: t = !un && (ka == kb);
      3'd2: t = !un && (ka <= kb);
      3'd3: t = !un && (ka > kb);
      3'd4: t = un || (ka != kb);
      3'd5: t = !un && (ka >= kb);
      3'd6: t = un;
      default: t = 1'b0;
    endcase
    if (inv || den) t = 1'b0;
    return {31'd0, t, !(inv || den), inv, den};
  endfunction

  function automatic int tag_of(input logic [31:0] a, input logic [31:0] b,
                                input logic [2:0] p);
    if (p == 3'd7) return 8;                                          // R8
    if ((is_nan(a) && !a[22]) || (is_nan(b) && !b[22])) return 4;     // R4
    if (is_nan(a) || is_nan(b)) return 5;                             // R5
    if (is_sub(a) || is_sub(b)) return 6;                             // R6
    if (a[30:0] == 0 && b[30:0] == 0) return 3;                       // R3
    if (p == 3'd6) return 2;                                          // R2
    return 1;                                                         // R1
  endfunction

  task automatic check(input int tag, input logic [34:0] act, input logic [34:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL R%0d actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // One cycle: drive at the falling edge, score the handshakes, then pass the rising edge.
  task automatic step(input logic v, input logic [31:0] a, input logic [31:0] b,
                      input logic [2:0] p, input logic rdy);
    logic [34:0] got;
    @(negedge clk);
    in_valid = v; in_a = a; in_b = b; in_pred = p; out_ready = rdy;
    #0.5;
    got = {out_result, out_wr_en, out_invalid, out_denorm};
    if (held_pending) begin
      // R9: stalled output must not change
      check(9, {got[34:1], out_valid}, {held_val[34:1], 1'b1});
      held_pending = 1'b0;
    end
    // R9: ready rule
    check(9, {31'd0, in_ready}, {31'd0, !out_valid || rdy});
    if (out_valid && rdy) begin
      if (exp_q.size() == 0) begin
        check(9, 35'd1, 35'd0);
      end else begin
        logic [34:0] e;
        int t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, got, e);
        if (e[1] || e[0]) check(7, got, e); // R7: write suppressed on exception
      end
    end else if (out_valid) begin
      held_pending = 1'b1;
      held_val = got;
    end
    if (v && in_ready) begin
      exp_q.push_back(model(a, b, p));
      tag_q.push_back(tag_of(a, b, p));
    end
  endtask

  function automatic logic [31:0] pick(input logic [31:0] other);
    int c;
    c = $urandom_range(0, 11);
    case (c)
      0: return 32'h0000_0000;
      1: return 32'h8000_0000;
      2: return {$urandom_range(0, 1) == 1, 31'h7F80_0000};
      3: return {1'b0, 8'hFF, 1'b1, 22'($urandom())};
      4: return {1'b1, 8'hFF, 1'b0, 22'($urandom()) | 22'd1};
      5: return {1'($urandom()), 8'h00, 23'($urandom()) | 23'd1};
      6: return other;
      7: return other ^ 32'h8000_0000;
      8: return other + 32'd1;
      default: return $urandom();
    endcase
  endfunction

  initial begin
    #200000;
    fails++;
    checks++;
    $display("FAIL R9 watchdog actual=timeout expected=completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; in_valid = 1'b0; in_a = '0; in_b = '0; in_pred = '0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    // R10: no valid output under reset
    check(10, {34'd0, out_valid}, 35'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(10, {34'd0, out_valid}, 35'd0);

    // Directed corners
    step(1, 32'h0000_0000, 32'h8000_0000, 3'd1, 1);            // R3 zeros equal
    step(1, 32'h8000_0000, 32'h0000_0000, 3'd0, 1);            // R3 not less
    step(1, 32'h7F80_0001, 32'h3F80_0000, 3'd1, 1);            // R4 sNaN eq
    step(1, 32'h7FC0_0000, 32'h3F80_0000, 3'd0, 1);            // R5 qNaN lt
    step(1, 32'h7FC0_0000, 32'h7FC0_0000, 3'd4, 1);            // R5 qNaN ne true
    step(1, 32'h7FC0_0000, 32'h3F80_0000, 3'd6, 1);            // R2 unordered
    step(1, 32'h0000_0001, 32'h3F80_0000, 3'd0, 1);            // R6 subnormal
    step(1, 32'h0000_0001, 32'hFF80_0001, 3'd1, 1);            // R6 priority: sNaN wins
    step(1, 32'h3F80_0000, 32'h4000_0000, 3'd7, 1);            // R8 undefined code
    step(1, 32'hBF80_0000, 32'h3F80_0000, 3'd0, 1);            // R1 -1 < 1
    step(1, 32'hC000_0000, 32'hBF80_0000, 3'd5, 1);            // R1 -2 >= -1 false
    step(1, 32'hFF80_0000, 32'h7F80_0000, 3'd2, 1);            // R1 -inf <= +inf
    // Back-pressure: stall a result for several cycles
    step(1, 32'h4000_0000, 32'h3F80_0000, 3'd3, 0);
    step(1, 32'h3F80_0000, 32'h3F80_0000, 3'd1, 0);
    step(1, 32'h3F80_0000, 32'h3F80_0000, 3'd1, 0);
    step(0, 32'h0, 32'h0, 3'd0, 1);
    step(0, 32'h0, 32'h0, 3'd0, 1);

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a, b;
      logic [2:0] p;
      a = $urandom();
      b = pick(a);
      if ($urandom_range(0, 2) == 0) a = pick(b);
      p = ($urandom_range(0, 15) == 0) ? 3'd7 : 3'($urandom_range(0, 6));
      step($urandom_range(0, 3) != 0, a, b, p, $urandom_range(0, 3) != 0);
    end
    repeat (3) step(0, 32'h0, 32'h0, 3'd0, 1);
    // R9: every accepted input came out
    check(9, 35'(exp_q.size()), 35'd0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule